// File: doc/BRIEF.md
# Four-Voice Note Allocator

This block assigns incoming key events to four voice slots for a polyphonic synthesizer. A key-down event claims a slot and a key-up event frees that slot. Each slot shows a busy flag and the note it carries. It also gives one-cycle attack and release strobes, which a downstream envelope stage uses to start its phases. The block keeps track of the order in which the held keys were pressed.

When a fifth key arrives while all four slots are busy, the slot of the key pressed earliest is reused. Keys can be let go in any order. The press order of the keys that stay held is renumbered so that it has no holes, and the next replacement therefore always picks the true earliest key still held.

Events come in over a valid/ready handshake, at most one per clock. All outputs are registered and change on the clock edge that accepts the event.

Top module: `poly_voice_alloc`

## Requirements
- R1: While reset is asserted and after it is released, every slot is idle: `voice_busy`, `voice_attack` and `voice_release` are all zero.
- R2: `ev_ready` is always 1. An event is taken on each clock edge where `ev_valid` is 1. Outputs reflect the event from that edge onward.
- R3: A key-down event is `ev_on`=1 with nonzero `ev_vel`. If its note is not held and a slot is idle, the event goes to the idle slot with the lowest index. That slot becomes busy with the note, and its bit of `voice_attack` is 1 for exactly one cycle.
- R4: A key-down for a note that is already held takes no second slot and changes no note field. It makes that note the most recently pressed one and pulses the attack bit of its slot.
- R5: A key-down for a new note while all four slots are busy replaces the note in the slot whose key was pressed earliest, and pulses that slot's attack bit.
- R6: A key-up event is `ev_on`=0. A key-up for a held note makes its slot idle and pulses that slot's bit of `voice_release` for exactly one cycle.
- R7: A key-up for a note that is not held has no effect. Busy flags and notes stay unchanged, and no strobe is raised.
- R8: A key-down with `ev_vel`=0 behaves exactly as a key-up for that note.
- R9: After releases in any order, the press order of the remaining keys is kept without gaps. Each later replacement takes the earliest-pressed key still held.
- R10: At most one strobe bit, across attack and release, is raised in any cycle, and no note is held in two slots at once. Slot i's note is `voice_note[7*i+6:7*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted (always 1) |
| ev_on | input | 1 | 1 = key-down, 0 = key-up |
| ev_note | input | 7 | Note number |
| ev_vel | input | 7 | Key velocity; 0 on key-down means key-up |
| voice_busy | output | 4 | Slot holds a note; level gate for the envelope |
| voice_note | output | 28 | Note per slot, 7 bits each, slot 0 in the low bits |
| voice_attack | output | 4 | One-cycle strobe: slot starts a note |
| voice_release | output | 4 | One-cycle strobe: slot's note ends |

## Verification
The checks assume that every input is known while `ev_valid` is 1 and that the block starts from reset, so the press-order counters begin from a consistent state. No assumption is made about the order of releases, and no assumption is made about a note being held before it is released. The stimulus changes inputs only on falling edges, starts each scenario from a reset, and deliberately sends duplicate key-downs, key-ups for notes that are not held, and a zero-velocity key-down. The property that each busy slot has its own press rank depends on the events being one per cycle, which the handshake enforces.

// File: rtl/poly_pkg.sv
package poly_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_NEW,
    ACT_STEAL,
    ACT_REFRESH,
    ACT_RELEASE
  } act_e;
endpackage

// File: rtl/poly_lookup.sv
module poly_lookup #(
  parameter int NUM_VOICES = 4,
  parameter int NOTE_W     = 7,
  localparam int AGE_W     = $clog2(NUM_VOICES),
  localparam int IDX_W     = $clog2(NUM_VOICES)
) (
  input  logic [NUM_VOICES-1:0]        busy,
  input  logic [NUM_VOICES*NOTE_W-1:0] notes,
  input  logic [NUM_VOICES*AGE_W-1:0]  ages,
  input  logic [NOTE_W-1:0]            key,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx,
  output logic [AGE_W-1:0]             hit_age,
  output logic                         free_any,
  output logic [IDX_W-1:0]             free_idx,
  output logic [IDX_W-1:0]             old_idx
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(NUM_VOICES - 1);

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    hit_age  = '0;
    free_any = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = NUM_VOICES - 1; i >= 0; i--) begin
      if (busy[i] && notes[i*NOTE_W +: NOTE_W] == key) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
        hit_age = ages[i*AGE_W +: AGE_W];
      end
      if (!busy[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (busy[i] && ages[i*AGE_W +: AGE_W] == OLDEST) begin
        old_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/poly_slot.sv
module poly_slot
  import poly_pkg::*;
#(
  parameter int NOTE_W = 7,
  parameter int AGE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic              sel,
  input  logic [AGE_W-1:0]  ref_age,
  input  logic [NOTE_W-1:0] new_note,
  output logic              busy,
  output logic [NOTE_W-1:0] note,
  output logic [AGE_W-1:0]  age,
  output logic              atk,
  output logic              rel
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic              busy_d;
  logic [NOTE_W-1:0] note_d;
  logic [AGE_W-1:0]  age_d;
  logic              atk_d, rel_d, upd_en;

  assign upd_en = (act != ACT_NONE);

  always_comb begin
    busy_d = busy;
    note_d = note;
    age_d  = age;
    atk_d  = 1'b0;
    rel_d  = 1'b0;
    unique case (act)
      ACT_NEW, ACT_STEAL: begin
        if (sel) begin
          busy_d = 1'b1;
          note_d = new_note;
          age_d  = '0;
          atk_d  = 1'b1;
        end else if (busy) begin
          age_d = age + 1'b1;
        end
      end
      ACT_REFRESH: begin
        if (sel) begin
          age_d = '0;
          atk_d = 1'b1;
        end else if (busy && age < ref_age) begin
          age_d = age + 1'b1;
        end
      end
      ACT_RELEASE: begin
        if (sel) begin
          busy_d = 1'b0;
          age_d  = '0;
          rel_d  = 1'b1;
        end else if (busy && age > ref_age) begin
          age_d = age - 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      note <= '0;
      age  <= '0;
    end else if (upd_en) begin
      busy <= busy_d;
      note <= note_d;
      age  <= age_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atk <= 1'b0;
      rel <= 1'b0;
    end else begin
      atk <= atk_d;
      rel <= rel_d;
    end
  end

  // R5
  steal_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && act == ACT_STEAL) |-> (busy && age == AGE_MAX));

  // R6
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && act == ACT_RELEASE) |=> (!busy && rel));

  // R4
  refresh_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && act == ACT_REFRESH) |=> (busy && $stable(note) && age == '0));
endmodule

// File: rtl/poly_voice_alloc.sv
module poly_voice_alloc
  import poly_pkg::*;
#(
  parameter int NUM_VOICES = 4,
  parameter int NOTE_W     = 7,
  parameter int VEL_W      = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ev_valid,
  output logic                         ev_ready,
  input  logic                         ev_on,
  input  logic [NOTE_W-1:0]            ev_note,
  input  logic [VEL_W-1:0]             ev_vel,
  output logic [NUM_VOICES-1:0]        voice_busy,
  output logic [NUM_VOICES*NOTE_W-1:0] voice_note,
  output logic [NUM_VOICES-1:0]        voice_attack,
  output logic [NUM_VOICES-1:0]        voice_release
);
  localparam int AGE_W = $clog2(NUM_VOICES);
  localparam int IDX_W = $clog2(NUM_VOICES);
  localparam int CNT_W = $clog2(NUM_VOICES + 1);

  logic [NUM_VOICES*AGE_W-1:0] ages;
  logic                        hit, free_any, key_down;
  logic [IDX_W-1:0]            hit_idx, free_idx, old_idx, tgt_idx;
  logic [AGE_W-1:0]            hit_age;
  act_e                        act;

  assign ev_ready = 1'b1;
  assign key_down = ev_on && (ev_vel != '0);

  poly_lookup #(.NUM_VOICES(NUM_VOICES), .NOTE_W(NOTE_W)) u_lookup (
    .busy    (voice_busy),
    .notes   (voice_note),
    .ages    (ages),
    .key     (ev_note),
    .hit     (hit),
    .hit_idx (hit_idx),
    .hit_age (hit_age),
    .free_any(free_any),
    .free_idx(free_idx),
    .old_idx (old_idx)
  );

  always_comb begin
    act     = ACT_NONE;
    tgt_idx = '0;
    if (ev_valid && ev_ready) begin
      if (key_down) begin
        if (hit) begin
          act     = ACT_REFRESH;
          tgt_idx = hit_idx;
        end else if (free_any) begin
          act     = ACT_NEW;
          tgt_idx = free_idx;
        end else begin
          act     = ACT_STEAL;
          tgt_idx = old_idx;
        end
      end else if (hit) begin
        act     = ACT_RELEASE;
        tgt_idx = hit_idx;
      end
    end
  end

  for (genvar g = 0; g < NUM_VOICES; g++) begin : g_slot
    poly_slot #(.NOTE_W(NOTE_W), .AGE_W(AGE_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .sel     (tgt_idx == IDX_W'(g)),
      .ref_age (hit_age),
      .new_note(ev_note),
      .busy    (voice_busy[g]),
      .note    (voice_note[g*NOTE_W +: NOTE_W]),
      .age     (ages[g*AGE_W +: AGE_W]),
      .atk     (voice_attack[g]),
      .rel     (voice_release[g])
    );
  end

  // Invariant state for checks: rank set and duplicate scan.
  logic [NUM_VOICES:0] rank_seen;
  logic [NUM_VOICES:0] rank_want;
  logic                dup_note;
  logic [CNT_W-1:0]    n_busy;

  always_comb begin
    rank_seen = '0;
    dup_note  = 1'b0;
    n_busy    = CNT_W'($countones(voice_busy));
    for (int i = 0; i < NUM_VOICES; i++) begin
      if (voice_busy[i]) rank_seen[ages[i*AGE_W +: AGE_W]] = 1'b1;
      for (int j = i + 1; j < NUM_VOICES; j++) begin
        if (voice_busy[i] && voice_busy[j] &&
            voice_note[i*NOTE_W +: NOTE_W] == voice_note[j*NOTE_W +: NOTE_W])
          dup_note = 1'b1;
      end
    end
    rank_want = (NUM_VOICES+1)'((1 << n_busy) - 1);
  end

  // R9
  rank_compact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rank_seen == rank_want);

  // R10
  no_dup_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_note);

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({voice_attack, voice_release}));

  // R8
  zero_vel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_on && ev_vel == '0 && hit) |=> (voice_release != '0));

  // R7
  stray_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !key_down && !hit) |=>
      ($stable(voice_busy) && voice_attack == '0 && voice_release == '0));
endmodule

// File: tb/sim_poly_voice_alloc.sv
module sim_poly_voice_alloc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, ev_on;
  logic [6:0]  ev_note, ev_vel;
  logic        ev_ready;
  logic [3:0]  voice_busy, voice_attack, voice_release;
  logic [27:0] voice_note;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  poly_voice_alloc u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_on(ev_on), .ev_note(ev_note), .ev_vel(ev_vel),
    .voice_busy(voice_busy), .voice_note(voice_note),
    .voice_attack(voice_attack), .voice_release(voice_release)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int slot_note(input int s);
    return int'(voice_note[s*7 +: 7]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ev_valid = 1'b0; ev_on = 1'b0; ev_note = '0; ev_vel = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One event on the next rising edge; returns at the falling edge after it.
  task automatic send(input bit on, input int note, input int vel);
    @(negedge clk);
    ev_valid = 1'b1; ev_on = on; ev_note = 7'(note); ev_vel = 7'(vel);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 busy in reset", voice_busy, 0);
    do_reset();
    chk("R1 busy after reset", voice_busy, 0);
    chk("R1 attack after reset", voice_attack, 0);
    chk("R1 release after reset", voice_release, 0);
    chk("R2 ready", ev_ready, 1);
  endtask

  task automatic t_fill();
    do_reset();
    send(1, 60, 90);
    chk("R3 first slot busy", voice_busy, 4'b0001);
    chk("R3 first note", slot_note(0), 60);
    chk("R3 attack pulse", voice_attack, 4'b0001);
    idle();
    chk("R3 attack one cycle", voice_attack, 0);
    send(1, 62, 90);
    send(1, 64, 90);
    send(1, 65, 90);
    chk("R3 four busy", voice_busy, 4'b1111);
    chk("R3 slot3 note", slot_note(3), 65);
    chk("R3 slot3 attack", voice_attack, 4'b1000);
  endtask

  task automatic t_refresh_steal();
    // held order oldest first: 60(s0) 62(s1) 64(s2) 65(s3)
    send(1, 62, 40);
    chk("R4 refresh attack", voice_attack, 4'b0010);
    chk("R4 refresh busy", voice_busy, 4'b1111);
    chk("R4 refresh note kept", slot_note(1), 62);
    chk("R10 no duplicate slot0", slot_note(0), 60);
    // order now 60 64 65 62
    send(1, 67, 90);
    chk("R5 steal oldest slot", voice_attack, 4'b0001);
    chk("R5 steal note", slot_note(0), 67);
    send(1, 69, 90);
    chk("R5 steal next (refreshed skipped)", voice_attack, 4'b0100);
    chk("R5 steal note 2", slot_note(2), 69);
    chk("R5 refreshed survives", slot_note(1), 62);
  endtask

  task automatic t_stray_off();
    // order 65(s3) 62(s1) 67(s0) 69(s2)
    send(0, 100, 0);
    chk("R7 busy kept", voice_busy, 4'b1111);
    chk("R7 no attack", voice_attack, 0);
    chk("R7 no release", voice_release, 0);
    chk("R7 notes kept", slot_note(3), 65);
  endtask

  task automatic t_out_of_order();
    send(0, 62, 0);
    chk("R6 release pulse", voice_release, 4'b0010);
    chk("R6 slot idle", voice_busy, 4'b1101);
    idle();
    chk("R6 release one cycle", voice_release, 0);
    send(1, 67, 0);
    chk("R8 zero vel releases", voice_release, 4'b0001);
    chk("R8 zero vel idle", voice_busy, 4'b1100);
    chk("R8 no attack", voice_attack, 0);
    // held: 65(s3) then 69(s2)
    send(1, 70, 90);
    chk("R3 lowest free slot", voice_attack, 4'b0001);
    send(1, 72, 90);
    chk("R3 next free slot", voice_attack, 4'b0010);
    send(1, 74, 90);
    chk("R9 steal earliest remaining", voice_attack, 4'b1000);
    chk("R9 steal note", slot_note(3), 74);
    send(1, 76, 90);
    chk("R9 steal second remaining", voice_attack, 4'b0100);
    send(1, 78, 90);
    chk("R9 steal third", voice_attack, 4'b0001);
    chk("R10 slot1 kept", slot_note(1), 72);
  endtask

  task automatic t_burst();
    do_reset();
    @(negedge clk);
    ev_valid = 1'b1; ev_on = 1'b1; ev_note = 7'd10; ev_vel = 7'd5;
    @(negedge clk);
    chk("R2 first of burst", voice_busy, 4'b0001);
    ev_note = 7'd11;
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R2 second of burst", voice_busy, 4'b0011);
    chk("R2 burst note", slot_note(1), 11);
    chk("R10 single strobe", voice_attack, 4'b0010);
  endtask

  initial begin
    rst_n = 1'b0; ev_valid = 1'b0; ev_on = 1'b0; ev_note = '0; ev_vel = '0;
    t_reset();
    t_fill();
    t_refresh_steal();
    t_stray_off();
    t_out_of_order();
    t_burst();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule